// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer Register Front End

This block holds three 16-bit down-counters behind a byte-wide register bus. Software reaches them through four addresses. Addresses 0, 1 and 2 each select one counter. Address 3 takes control words. A control word names a channel and sets three things for it: the byte access pattern, the counting mode and a decimal flag. The decimal flag is stored but does not change how the channel counts. Counts are written one byte at a time. The same address can latch a running count, or latch a status byte, so that software can read either one back consistently.

Every channel counts on a shared count-clock enable, `cnt_en`, which is sampled on the rising edge of `clk`. A channel can run as a rate generator, which gives one low pulse per period. It can also run as a square-wave generator. The other mode codes park the channel with its output high.

The bus is a plain register port. `wr_en` and `rd_en` are single-cycle strobes that are always accepted, so there is no back-pressure. Read data is registered: it appears on `rdata` one cycle after `rd_en` and holds until the next read.

Top module: `pit_regs`

## Requirements
- R1: After reset every `tmr_out` bit is 1 and `rdata` is 0. A status read-back of any channel then returns 0xB0, which is output 1, null 0, access 11, mode 000 and binary.
- R2: A write to address 3 with bits 7:6 = n (where n < 3) and bits 5:4 not 00 programs channel n. Bits 5:4 become the access field, bits 3:1 the mode and bit 0 the decimal flag. Programming also drives the output high, sets the null flag and stops the channel until a new count is loaded. The output changes only on an edge that has `cnt_en` high or a bus write.
- R3: Access field 11 loads a count as two writes to the channel's address, the low byte first. Access 01 loads the low byte alone, with the high byte taken as 0. Access 10 loads the high byte alone, with the low byte taken as 0. The field also selects the byte order for reads.
- R4: A count of 0 counts as 65536. After it is loaded the counter reads 0x0000, and after one further enabled edge it reads 0xFFFF.
- R5: Modes 2 and 6 are the rate generator. With count N, the output is high for N-1 enabled edges and then low for exactly one.
- R6: Modes 3 and 7 are the square wave. With count N, the output is high for ceil(N/2) enabled edges and low for floor(N/2).
- R7: In modes 2, 3, 6 and 7, a completed count write of 1 is discarded. The previous count stays in effect and the null flag is not set.
- R8: A control write with bits 5:4 = 00 freezes the selected counter's value. The following reads return the frozen bytes in the order the access field gives. A second freeze command is ignored until every frozen byte has been read.
- R9: The read-back command has bits 7:6 = 11. Bit 1, bit 2 or bit 3 selects channel 0, 1 or 2. If bit 4 is 0, it captures status; if bit 5 is 0, it freezes the count. The next read of that channel returns the status byte: bit 7 is the output, bit 6 is null, bits 5:4 are access, bits 3:1 are mode and bit 0 is decimal.
- R10: The null flag sets when a count write completes. It clears when that count moves into the counting element: on the first enabled edge of an idle channel, or at the next reload point of a running one.
- R11: Modes 0, 1, 4 and 5 do not count. The output stays high, and a loaded count keeps its null flag set.
- R12: A read of address 3 returns 0. A channel read with no freeze and no status pending returns the live count byte.
- R13: A count written while a channel is running takes effect only at its next reload. In mode 2 that is the edge after the low pulse. In mode 3 it is the toggle back to high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Shared count-clock enable, one pulse per count |
| addr | input | 2 | Register address: 0 to 2 are channels, 3 is control |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data, valid the cycle after `rd_en` |
| tmr_out | output | 3 | Channel outputs, bit n for channel n |

## Verification
The checker watches properties that hold on every cycle. In the rate mode, a low output always returns high on the next enabled edge. Halted modes keep the output high. The null flag rises only after a bus write. No output moves without an enable or a write, and a control-address read returns 0. Several properties need whole scenarios, so only the bench shows them. These are the exact high and low run lengths for random counts, the byte order of two-byte loads and frozen reads, the ignored second freeze, the rejection of a count of 1, the status byte contents, and the deferred take-over of a count written mid-run.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CH_N   = 3;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_FREEZE = 2'b00,
    ACC_LO     = 2'b01,
    ACC_HI     = 2'b10,
    ACC_WORD   = 2'b11
  } acc_e;

  // Field order matches control-word bits 5:0.
  typedef struct packed {
    acc_e              acc;
    logic [MODE_W-1:0] mode;
    logic              dec;
  } cfg_t;

  localparam cfg_t CFG_RST = '{acc: ACC_WORD, mode: '0, dec: 1'b0};

  typedef struct packed {
    logic prog;
    logic frz_cnt;
    logic cap_sts;
    logic wr_byte;
    logic rd_byte;
  } chan_cmd_t;

  function automatic logic mode_runs(input logic [MODE_W-1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_square(input logic [MODE_W-1:0] m);
    return m[1] & m[0];
  endfunction

  // Half of a count, zero meaning 2**CNT_W; rounds up or down.
  function automatic logic [CNT_W-1:0] half_up(input logic [CNT_W-1:0] n);
    logic [CNT_W:0] w;
    w = (n == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, n};
    return CNT_W'((w + 1'b1) >> 1);
  endfunction

  function automatic logic [CNT_W-1:0] half_dn(input logic [CNT_W-1:0] n);
    logic [CNT_W:0] w;
    w = (n == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, n};
    return CNT_W'(w >> 1);
  endfunction
endpackage

// File: rtl/pit_cmd_dec.sv
module pit_cmd_dec
  import pit_pkg::*;
(
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [1:0]                  addr,
  input  logic [BYTE_W-1:0]           wdata,
  output chan_cmd_t [CH_N-1:0]        cmd
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic ctrl_wr, rb_cmd;
  assign ctrl_wr = wr_en && (addr == CTRL_ADDR);
  assign rb_cmd  = (wdata[7:6] == 2'b11);

  for (genvar i = 0; i < CH_N; i++) begin : g_dec
    logic sel_me;
    assign sel_me = (wdata[7:6] == 2'(i));
    assign cmd[i].prog    = ctrl_wr && sel_me && (wdata[5:4] != 2'b00);
    assign cmd[i].frz_cnt = ctrl_wr && ((sel_me && (wdata[5:4] == 2'b00)) ||
                                        (rb_cmd && !wdata[5] && wdata[i+1]));
    assign cmd[i].cap_sts = ctrl_wr && rb_cmd && !wdata[4] && wdata[i+1];
    assign cmd[i].wr_byte = wr_en && (addr == 2'(i));
    assign cmd[i].rd_byte = rd_en && (addr == 2'(i));
  end
endmodule

// File: rtl/pit_chan_regs.sv
module pit_chan_regs
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  chan_cmd_t         cmd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              out_lvl,
  input  logic              null_f,
  output cfg_t              cfg,
  output logic [CNT_W-1:0]  cr,
  output logic              load,
  output logic [BYTE_W-1:0] rd_val
);
  logic [BYTE_W-1:0] lo_tmp;
  logic              wr_hi, rd_hi;
  logic [CNT_W-1:0]  frz_q;
  logic              frz_v;
  logic [BYTE_W-1:0] sts_q;
  logic              sts_v;
  logic              done;
  logic [CNT_W-1:0]  val;

  // Count-write completion and value assembly.
  always_comb begin
    done = 1'b0;
    val  = cr;
    if (cmd.wr_byte) begin
      unique case (cfg.acc)
        ACC_LO:   begin done = 1'b1; val = {{BYTE_W{1'b0}}, wdata}; end
        ACC_HI:   begin done = 1'b1; val = {wdata, {BYTE_W{1'b0}}}; end
        ACC_WORD: begin done = wr_hi; val = {wdata, lo_tmp}; end
        default:  begin done = 1'b0; end
      endcase
    end
    load = done && !(mode_runs(cfg.mode) && (val == CNT_W'(1)));
  end

  // Read byte selection.
  logic [CNT_W-1:0] src;
  logic             pick_hi, last_rd;
  always_comb begin
    src     = frz_v ? frz_q : cnt;
    pick_hi = (cfg.acc == ACC_HI) || ((cfg.acc == ACC_WORD) && rd_hi);
    last_rd = (cfg.acc != ACC_WORD) || rd_hi;
    rd_val  = sts_v ? sts_q : (pick_hi ? src[CNT_W-1 -: BYTE_W] : src[BYTE_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg    <= CFG_RST;
      cr     <= '0;
      lo_tmp <= '0;
      wr_hi  <= 1'b0;
      rd_hi  <= 1'b0;
      frz_q  <= '0;
      frz_v  <= 1'b0;
      sts_q  <= '0;
      sts_v  <= 1'b0;
    end else if (cmd.prog) begin
      cfg   <= cfg_t'(wdata[5:0]);
      wr_hi <= 1'b0;
      rd_hi <= 1'b0;
      frz_v <= 1'b0;
      sts_v <= 1'b0;
    end else begin
      if (cmd.wr_byte && (cfg.acc == ACC_WORD)) begin
        if (!wr_hi) lo_tmp <= wdata;
        wr_hi <= !wr_hi;
      end
      if (load) cr <= val;
      if (cmd.frz_cnt && !frz_v) begin
        frz_q <= cnt;
        frz_v <= 1'b1;
      end
      if (cmd.cap_sts && !sts_v) begin
        sts_q <= {out_lvl, null_f, cfg};
        sts_v <= 1'b1;
      end
      if (cmd.rd_byte) begin
        if (sts_v) begin
          sts_v <= 1'b0;
        end else begin
          if (cfg.acc == ACC_WORD) rd_hi <= !rd_hi;
          if (frz_v && last_rd) frz_v <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pit_chan_core.sv
module pit_chan_core
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              prog,
  input  logic              load,
  input  logic [MODE_W-1:0] mode,
  input  logic [CNT_W-1:0]  cr,
  output logic [CNT_W-1:0]  cnt,
  output logic              out_lvl,
  output logic              null_f
);
  logic             armed, pend;
  logic [CNT_W-1:0] ac;
  logic [CNT_W-1:0] eff;
  logic             sq;

  assign sq  = mode_square(mode);
  assign eff = pend ? cr : ac;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      out_lvl <= 1'b1;
      armed   <= 1'b0;
      pend    <= 1'b0;
      null_f  <= 1'b0;
      ac      <= '0;
    end else if (prog) begin
      armed   <= 1'b0;
      pend    <= 1'b0;
      null_f  <= 1'b1;
      out_lvl <= 1'b1;
    end else begin
      if (cnt_en && mode_runs(mode)) begin
        if (!armed) begin
          if (pend) begin
            armed   <= 1'b1;
            pend    <= 1'b0;
            null_f  <= 1'b0;
            ac      <= cr;
            out_lvl <= 1'b1;
            cnt     <= sq ? half_up(cr) : cr;
          end
        end else if (!sq) begin
          if (cnt == CNT_W'(1)) begin
            cnt     <= eff;
            out_lvl <= 1'b1;
            if (pend) begin
              ac     <= cr;
              pend   <= 1'b0;
              null_f <= 1'b0;
            end
          end else begin
            cnt     <= cnt - CNT_W'(1);
            out_lvl <= (cnt != CNT_W'(2));
          end
        end else begin
          if (cnt == CNT_W'(1)) begin
            if (out_lvl) begin
              cnt     <= half_dn(ac);
              out_lvl <= 1'b0;
            end else begin
              cnt     <= half_up(eff);
              out_lvl <= 1'b1;
              if (pend) begin
                ac     <= cr;
                pend   <= 1'b0;
                null_f <= 1'b0;
              end
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
      end
      if (load) begin
        pend   <= 1'b1;
        null_f <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [2:0]        tmr_out
);
  chan_cmd_t [CH_N-1:0]             cmd;
  cfg_t      [CH_N-1:0]             cfg_a;
  logic      [CH_N-1:0][CNT_W-1:0]  cr_a, cnt_a;
  logic      [CH_N-1:0][BYTE_W-1:0] rd_val;
  logic      [CH_N-1:0]             load_a, null_vec;
  logic      [2*CH_N-1:0]           ch_mode;
  logic      [BYTE_W-1:0]           rsel;

  pit_cmd_dec u_dec (
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .cmd   (cmd)
  );

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    pit_chan_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd[i]),
      .wdata   (wdata),
      .cnt     (cnt_a[i]),
      .out_lvl (tmr_out[i]),
      .null_f  (null_vec[i]),
      .cfg     (cfg_a[i]),
      .cr      (cr_a[i]),
      .load    (load_a[i]),
      .rd_val  (rd_val[i])
    );

    pit_chan_core u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_en  (cnt_en),
      .prog    (cmd[i].prog),
      .load    (load_a[i]),
      .mode    (cfg_a[i].mode),
      .cr      (cr_a[i]),
      .cnt     (cnt_a[i]),
      .out_lvl (tmr_out[i]),
      .null_f  (null_vec[i])
    );

    assign ch_mode[2*i +: 2] = cfg_a[i].mode[1:0];
  end

  always_comb begin
    rsel = '0;
    for (int k = 0; k < CH_N; k++) begin
      if (addr == 2'(k)) rsel = rd_val[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rsel;
  end
endmodule

// File: rtl/pit_regs_chk.sv
module pit_regs_chk
  import pit_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en,
  input logic [1:0]        addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        rdata,
  input logic [2:0]        tmr_out,
  input logic [2*CH_N-1:0] ch_mode,
  input logic [CH_N-1:0]   ch_null
);
  // R12
  rd_ctrl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3) |=> (rdata == 8'h00));

  for (genvar i = 0; i < CH_N; i++) begin : g_chk
    // R5
    rate_low_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_mode[2*i +: 2] == 2'b10 && !tmr_out[i] && cnt_en && !wr_en) |=> tmr_out[i]);
    // R11
    halted_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_mode[2*i+1] |-> tmr_out[i]);
    // R10
    null_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_null[i]) |-> $past(wr_en));
    // R2
    out_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tmr_out[i]) |-> ($past(cnt_en) || $past(wr_en)));
  end
endmodule

bind pit_regs pit_regs_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .cnt_en  (cnt_en),
  .addr    (addr),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .rdata   (rdata),
  .tmr_out (tmr_out),
  .ch_mode (ch_mode),
  .ch_null (null_vec)
);

// File: tb/pit_regs_tb_top.sv
`timescale 1ns/1ps
module pit_regs_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [2:0] tmr_out;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pit_regs dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .tmr_out(tmr_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic step(input int gap);
    @(negedge clk); cnt_en = 1'b1;
    @(negedge clk); cnt_en = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic status(input int ch, output logic [7:0] s);
    bus_wr(2'd3, 8'hE0 | (8'd2 << ch));
    bus_rd(2'(ch), s);
  endtask

  task automatic measure(input int ch, output int lo, output int hi);
    int g = 0;
    lo = 0; hi = 0;
    while (tmr_out[ch] === 1'b0 && g < 400) begin step($urandom % 3); g++; end
    while (tmr_out[ch] === 1'b1 && g < 400) begin step($urandom % 3); g++; end
    lo = 1; step($urandom % 3);
    while (tmr_out[ch] === 1'b0 && g < 400) begin lo++; step($urandom % 3); g++; end
    hi = 1; step($urandom % 3);
    while (tmr_out[ch] === 1'b1 && g < 400) begin hi++; step($urandom % 3); g++; end
  endtask

  function automatic int exp_hi(input logic sq, input int n);
    return sq ? (n + 1) / 2 : n - 1;
  endfunction

  function automatic int exp_lo(input logic sq, input int n);
    return sq ? n / 2 : 1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    int lo, hi;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs after reset", tmr_out, 3'b111);
    check("R1 rdata after reset", rdata, 8'h00);
    status(0, b); check("R1 R9 reset status ch0", b, 8'hB0);
    bus_rd(2'd3, b); check("R12 control read", b, 8'h00);

    // R2 program ch1 rate mode, word access
    bus_wr(2'd3, 8'h74);
    status(1, b); check("R2 R9 status after program", b, 8'hF4);
    bus_wr(2'd1, 8'h05); bus_wr(2'd1, 8'h00);
    status(1, b); check("R10 null set after load", b, 8'hF4);
    step(0);
    status(1, b); check("R10 null clear after transfer", b, 8'hB4);
    bus_rd(2'd1, b); check("R12 live low byte", b, 8'h05);
    bus_rd(2'd1, b); check("R12 live high byte", b, 8'h00);
    measure(1, lo, hi);
    check("R5 rate high run N=5", hi, 4);
    check("R5 rate low run N=5", lo, 1);

    // R5 R6 random patterns, including mode aliases 6 and 7
    for (int t = 0; t < 8; t++) begin
      int ch = $urandom % 3;
      int n = 2 + ($urandom % 23);
      logic sq = 1'($urandom % 2);
      logic alias_m = 1'($urandom % 2);
      bus_wr(2'd3, {2'(ch), 2'b11, alias_m, 1'b1, sq, 1'b0});
      bus_wr(2'(ch), 8'(n)); bus_wr(2'(ch), 8'h00);
      measure(ch, lo, hi);
      check(sq ? "R6 square high run" : "R5 rate high run", hi, exp_hi(sq, n));
      check(sq ? "R6 square low run" : "R5 rate low run", lo, exp_lo(sq, n));
    end

    // R7 count of 1 discarded
    bus_wr(2'd3, 8'h34);
    bus_wr(2'd0, 8'h04); bus_wr(2'd0, 8'h00);
    measure(0, lo, hi);
    check("R5 ch0 high N=4", hi, 3);
    bus_wr(2'd0, 8'h01); bus_wr(2'd0, 8'h00);
    status(0, b); check("R7 null not set by count 1", b & 8'h7F, 8'h34);
    measure(0, lo, hi);
    check("R7 period kept high", hi, 3);
    check("R7 period kept low", lo, 1);

    // R13 mid-run count change
    bus_wr(2'd0, 8'h07); bus_wr(2'd0, 8'h00);
    status(0, b); check("R10 null set mid-run", b & 8'h7F, 8'h74);
    measure(0, lo, hi);
    check("R13 new high run", hi, 6);
    check("R13 new low run", lo, 1);
    status(0, b); check("R10 null clear at reload", b & 8'h7F, 8'h34);

    // R8 freeze and ignored second freeze
    bus_wr(2'd3, 8'hB4);
    bus_wr(2'd2, 8'h00); bus_wr(2'd2, 8'h03);
    step(0);
    bus_wr(2'd3, 8'h80);
    bus_rd(2'd2, b); check("R8 frozen low", b, 8'h00);
    for (int k = 0; k < 5; k++) step(0);
    bus_wr(2'd3, 8'h80);
    bus_rd(2'd2, b); check("R8 frozen high kept", b, 8'h03);
    bus_wr(2'd3, 8'h80);
    bus_rd(2'd2, b); check("R8 new freeze low", b, 8'hFB);
    bus_rd(2'd2, b); check("R8 new freeze high", b, 8'h02);

    // R4 zero count
    bus_wr(2'd3, 8'hB4);
    bus_wr(2'd2, 8'h00); bus_wr(2'd2, 8'h00);
    step(0);
    bus_wr(2'd3, 8'h80);
    bus_rd(2'd2, b); check("R4 zero low", b, 8'h00);
    bus_rd(2'd2, b); check("R4 zero high", b, 8'h00);
    step(0);
    bus_wr(2'd3, 8'h80);
    bus_rd(2'd2, b); check("R4 wrap low", b, 8'hFF);
    bus_rd(2'd2, b); check("R4 wrap high", b, 8'hFF);

    // R3 single-byte access
    bus_wr(2'd3, 8'h14);
    bus_wr(2'd0, 8'h06);
    status(0, b); check("R3 low-only loaded, status", b, 8'hD4);
    measure(0, lo, hi);
    check("R3 low-only high run", hi, 5);
    bus_wr(2'd3, 8'h24);
    bus_wr(2'd0, 8'h01);
    step(0);
    bus_wr(2'd3, 8'h00);
    bus_rd(2'd0, b); check("R3 high-only frozen byte", b, 8'h01);

    // R11 halted mode
    bus_wr(2'd3, 8'h70);
    bus_wr(2'd1, 8'h05); bus_wr(2'd1, 8'h00);
    lo = 0;
    for (int k = 0; k < 10; k++) begin step(0); if (tmr_out[1] !== 1'b1) lo++; end
    check("R11 output held high", lo, 0);
    status(1, b); check("R11 null stays set", b, 8'hF0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule